// File: doc/BRIEF.md
# TDM Serial Audio Transmitter

This block turns parallel audio samples into a serial bit stream for a codec or a shared time-division bus. Software or a DMA engine writes 16-bit samples into a 16-entry transmit FIFO. The serializer follows an external bit clock and frame sync, both sampled in the fabric clock domain. For each enabled slot of a frame it takes one sample from the FIFO and shifts it out MSB first on `tx_data`. While it sends a word it asserts `tx_oe`, which the pad ring uses to drive the pin. Between words the pin is left floating.

The block has two framing modes. In single-slot mode each frame carries exactly one word. In multi-slot mode each frame carries between one and four words. Each of these slots has its own enable bit, so several devices can share the line. Words are either 8 or 16 bits long. If a sample is missing when an enabled slot begins, a zero word goes out and a sticky underrun flag is set. When one word is followed directly by another, the output stays driven across the boundary. Otherwise it is released in the second half of the final bit.

Top module: `tdm_tx`

## Requirements
- R1: After reset, `tx_oe` is 0, `tx_underrun` is 0 and `fifo_full` is 0. While no frame sync is seen, `tx_oe` stays 0 even though the bit clock toggles.
- R2: Frame sync is sampled on falling bit-clock edges. When it is 1 there, the first bit of slot 0 (its MSB) is driven from the next rising edge. Each following rising edge presents the next lower bit.
- R3: `tx_data` changes only in response to a rising bit-clock edge, or when the block is disabled. Its value has no meaning while `tx_oe` is 0.
- R4: `wide_words`=1 selects 16-bit words, sent from bit 15 down to bit 0. `wide_words`=0 selects 8-bit words, and then bits 7..0 of the FIFO entry are sent (7 first) while bits 15..8 are ignored.
- R5: With `net_mode`=0, each frame carries exactly one word, and that slot is always used whatever `slot_en` holds.
- R6: With `net_mode`=1, a frame carries `slot_last`+1 slots in ascending order (slot 0 first). The slots follow one another with no gap bits, and each enabled slot consumes one FIFO entry.
- R7: In multi-slot mode, a slot whose bit in `slot_en` (bit i for slot i) is 0 keeps `tx_oe` at 0 for its whole duration and consumes no FIFO entry.
- R8: On the falling bit-clock edge inside the last bit of a word, `tx_oe` drops to 0, unless a word follows immediately.
- R9: A word follows immediately when the next slot of the frame is enabled, or when frame sync is sampled 1 on that same falling edge and slot 0 of the new frame is used. In that case `tx_oe` stays 1 across the boundary.
- R10: The FIFO holds 16 entries. `fifo_full` is 1 when it holds 16, and a write while full is dropped.
- R11: If the FIFO is empty when an enabled slot starts, that slot sends all zeros with `tx_oe`=1. `tx_underrun` then becomes 1 and stays 1 until reset.
- R12: While `tx_enable`=0, `tx_oe` is 0 and the serializer returns to idle. After re-enabling, nothing is driven until the next frame sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock; bit clock and frame sync are sampled with it |
| rst | input | 1 | Synchronous active-high reset |
| tx_enable | input | 1 | Serializer enable |
| bclk | input | 1 | Serial bit clock, free running |
| fsync | input | 1 | Frame sync, sampled on falling bit-clock edges |
| net_mode | input | 1 | 0: one slot per frame, 1: multi-slot frames |
| wide_words | input | 1 | 0: 8-bit words, 1: 16-bit words |
| slot_last | input | 2 | Index of the final slot in multi-slot mode |
| slot_en | input | 4 | Per-slot enables, bit i for slot i (multi-slot mode) |
| wr_en | input | 1 | FIFO write strobe |
| wr_data | input | 16 | FIFO write data |
| fifo_full | output | 1 | FIFO holds 16 entries |
| tx_data | output | 1 | Serial data, meaningful while tx_oe is 1 |
| tx_oe | output | 1 | Pin drive enable |
| tx_underrun | output | 1 | Sticky: an enabled slot found the FIFO empty |

## Verification
The bench targets the word boundary. If the follow-on check were wrong, the design would either release the pin between two chained slots or frames, or keep driving it into a disabled slot or idle time. These show up as a wrong `tx_oe` in the low half of a last bit.

A disabled slot that still popped the FIFO would shift every later sample by one slot. The next slot would then carry the wrong data and a false underrun would appear.

The FIFO is filled past its depth and then drained through four chained frames. A design that overwrote an entry or kept the extra write would send a non-zero word in the following frame, where zeros and the underrun flag are expected. Dropping the enable mid-word checks that the pin is released and that no stale frame resumes after re-enabling.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int TX_WORD_W     = 16;
    localparam int TX_SLOTS      = 4;
    localparam int TX_SLOT_W     = $clog2(TX_SLOTS);
    localparam int TX_CNT_W      = $clog2(TX_WORD_W);
    localparam int TX_FIFO_DEPTH = 16;

    typedef enum logic {
        FRAME_SINGLE = 1'b0,
        FRAME_MULTI  = 1'b1
    } frame_mode_e;

    typedef enum logic {
        LEN_SHORT = 1'b0,
        LEN_LONG  = 1'b1
    } word_len_e;

    typedef struct packed {
        frame_mode_e           mode;
        word_len_e             len;
        logic [TX_SLOT_W-1:0]  last_slot;
        logic [TX_SLOTS-1:0]   slot_en;
    } tx_cfg_t;

    typedef struct packed {
        logic                  active;
        logic                  start_pend;
        logic                  oe;
        logic [TX_SLOT_W-1:0]  slot;
        logic [TX_CNT_W-1:0]   bitn;
        logic [TX_WORD_W-1:0]  sh;
    } ser_state_t;

    // A slot carries data when framing is single-slot or its enable is set.
    function automatic logic slot_live(tx_cfg_t c, logic [TX_SLOT_W-1:0] idx);
        return (c.mode == FRAME_SINGLE) || c.slot_en[idx];
    endfunction

    function automatic logic [TX_SLOT_W-1:0] final_slot(tx_cfg_t c);
        return (c.mode == FRAME_SINGLE) ? '0 : c.last_slot;
    endfunction

    function automatic logic [TX_CNT_W-1:0] final_bit(tx_cfg_t c);
        return (c.len == LEN_LONG) ? TX_CNT_W'(TX_WORD_W - 1) : TX_CNT_W'(TX_WORD_W / 2 - 1);
    endfunction

    // Left-justify a sample so the shift register MSB is always the first bit.
    function automatic logic [TX_WORD_W-1:0] align_word(logic [TX_WORD_W-1:0] d, word_len_e l);
        return (l == LEN_LONG) ? d : {d[TX_WORD_W/2-1:0], {(TX_WORD_W/2){1'b0}}};
    endfunction

endpackage

// File: rtl/tdm_tx_edges.sv
module tdm_tx_edges #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic bclk_in,
    input  logic fsync_in,
    output logic rise,
    output logic fall,
    output logic fsync
);
    logic [1:0] synced;
    logic       bclk_d;

    generate
        if (STAGES == 0) begin : g_direct
            assign synced = {bclk_in, fsync_in};
        end else begin : g_sync
            logic [1:0] chain [STAGES];
            always_ff @(posedge clk) begin
                if (rst) begin
                    for (int i = 0; i < STAGES; i++) chain[i] <= '0;
                end else begin
                    chain[0] <= {bclk_in, fsync_in};
                    for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
                end
            end
            assign synced = chain[STAGES-1];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) bclk_d <= 1'b0;
        else     bclk_d <= synced[1];
    end

    assign rise  = synced[1] & ~bclk_d;
    assign fall  = ~synced[1] & bclk_d;
    assign fsync = synced[0];
endmodule

// File: rtl/tdm_tx_fifo.sv
module tdm_tx_fifo #(
    parameter  int WIDTH = 16,
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             pop,
    output logic [WIDTH-1:0] rd_data,
    output logic             full,
    output logic             empty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             push;

    assign push    = wr_en && !full;
    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign rd_data = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (push) mem[wr_ptr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 en,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 fsync,
    input  tx_cfg_t              cfg,
    input  logic                 fifo_empty,
    input  logic [TX_WORD_W-1:0] fifo_data,
    output logic                 pop,
    output logic                 tx_data,
    output logic                 tx_oe,
    output logic                 underrun
);
    ser_state_t           st;
    logic                 at_last, more, load_go, load_on, follow;
    logic [TX_SLOT_W-1:0] nxt_slot, load_idx;

    always_comb begin
        nxt_slot = st.slot + 1'b1;
        at_last  = st.active && (st.bitn == final_bit(cfg));
        more     = st.active && (st.slot < final_slot(cfg));
        load_go  = rise && (st.start_pend || (at_last && more));
        load_idx = st.start_pend ? '0 : nxt_slot;
        load_on  = slot_live(cfg, load_idx);
        // Word that starts on the coming rising edge keeps the pin driven.
        follow   = fsync ? slot_live(cfg, '0) : (more && slot_live(cfg, nxt_slot));
    end

    assign pop     = en && load_go && load_on && !fifo_empty;
    assign tx_data = st.sh[TX_WORD_W-1];
    assign tx_oe   = st.oe;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            st <= '0;
        end else if (fall) begin
            st.start_pend <= fsync;
            if (at_last && !follow) st.oe <= 1'b0;
        end else if (rise) begin
            st.start_pend <= 1'b0;
            if (load_go) begin
                st.active <= 1'b1;
                st.slot   <= load_idx;
                st.bitn   <= '0;
                st.oe     <= load_on;
                st.sh     <= (load_on && !fifo_empty) ? align_word(fifo_data, cfg.len) : '0;
            end else if (at_last) begin
                st.active <= 1'b0;
                st.oe     <= 1'b0;
            end else if (st.active) begin
                st.bitn <= st.bitn + 1'b1;
                st.sh   <= {st.sh[TX_WORD_W-2:0], 1'b0};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) underrun <= 1'b0;
        else if (en && load_go && load_on && fifo_empty) underrun <= 1'b1;
    end
endmodule

// File: rtl/tdm_tx.sv
module tdm_tx
    import tdm_tx_pkg::*;
#(
    parameter int FIFO_DEPTH  = TX_FIFO_DEPTH,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tx_enable,
    input  logic                 bclk,
    input  logic                 fsync,
    input  logic                 net_mode,
    input  logic                 wide_words,
    input  logic [TX_SLOT_W-1:0] slot_last,
    input  logic [TX_SLOTS-1:0]  slot_en,
    input  logic                 wr_en,
    input  logic [TX_WORD_W-1:0] wr_data,
    output logic                 fifo_full,
    output logic                 tx_data,
    output logic                 tx_oe,
    output logic                 tx_underrun
);
    tx_cfg_t              cfg;
    logic                 bit_rise, bit_fall, fs_sync;
    logic                 fifo_pop, fifo_empty;
    logic [TX_WORD_W-1:0] fifo_rd;

    assign cfg = '{mode:      frame_mode_e'(net_mode),
                   len:       word_len_e'(wide_words),
                   last_slot: slot_last,
                   slot_en:   slot_en};

    tdm_tx_edges #(.STAGES(SYNC_STAGES)) u_edges (
        .clk      (clk),
        .rst      (rst),
        .bclk_in  (bclk),
        .fsync_in (fsync),
        .rise     (bit_rise),
        .fall     (bit_fall),
        .fsync    (fs_sync)
    );

    tdm_tx_fifo #(.WIDTH(TX_WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .pop     (fifo_pop),
        .rd_data (fifo_rd),
        .full    (fifo_full),
        .empty   (fifo_empty)
    );

    tdm_tx_serializer u_ser (
        .clk        (clk),
        .rst        (rst),
        .en         (tx_enable),
        .rise       (bit_rise),
        .fall       (bit_fall),
        .fsync      (fs_sync),
        .cfg        (cfg),
        .fifo_empty (fifo_empty),
        .fifo_data  (fifo_rd),
        .pop        (fifo_pop),
        .tx_data    (tx_data),
        .tx_oe      (tx_oe),
        .underrun   (tx_underrun)
    );
endmodule

// File: rtl/tdm_tx_checker.sv
module tdm_tx_checker (
    input logic clk,
    input logic rst,
    input logic tx_enable,
    input logic tx_oe,
    input logic tx_data,
    input logic tx_underrun,
    input logic rise,
    input logic fall,
    input logic fifo_pop,
    input logic fifo_empty,
    input logic fifo_full,
    input logic wr_en
);
    assert_oe_starts_on_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(tx_oe) |-> $past(rise));

    assert_data_moves_on_rise_R3: assert property (@(posedge clk) disable iff (rst)
        (!rise && tx_enable) |=> $stable(tx_data));

    assert_oe_release_timing_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(tx_oe) |-> ($past(fall) || $past(rise) || !$past(tx_enable)));

    assert_no_pop_empty_R10: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !fifo_empty);

    assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
        (fifo_full && wr_en && !fifo_pop) |=> fifo_full);

    assert_underrun_sticky_R11: assert property (@(posedge clk) disable iff (rst)
        tx_underrun |=> tx_underrun);

    assert_quiet_when_off_R12: assert property (@(posedge clk) disable iff (rst)
        !tx_enable |=> !tx_oe);
endmodule

bind tdm_tx tdm_tx_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_enable   (tx_enable),
    .tx_oe       (tx_oe),
    .tx_data     (tx_data),
    .tx_underrun (tx_underrun),
    .rise        (bit_rise),
    .fall        (bit_fall),
    .fifo_pop    (fifo_pop),
    .fifo_empty  (fifo_empty),
    .fifo_full   (fifo_full),
    .wr_en       (wr_en)
);

// File: tb/tdm_tx_bench.sv
module tdm_tx_bench;
    localparam int HALF  = 6;
    localparam int PROBE = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tx_enable = 1'b0;
    logic        bclk = 1'b0;
    logic        fsync = 1'b0;
    logic        net_mode = 1'b0;
    logic        wide_words = 1'b1;
    logic [1:0]  slot_last = 2'd0;
    logic [3:0]  slot_en = 4'h0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic        fifo_full, tx_data, tx_oe, tx_underrun;

    always #4 clk = ~clk;

    tdm_tx u_tdm_tx (
        .clk(clk), .rst(rst), .tx_enable(tx_enable), .bclk(bclk), .fsync(fsync),
        .net_mode(net_mode), .wide_words(wide_words), .slot_last(slot_last),
        .slot_en(slot_en), .wr_en(wr_en), .wr_data(wr_data), .fifo_full(fifo_full),
        .tx_data(tx_data), .tx_oe(tx_oe), .tx_underrun(tx_underrun)
    );

    typedef struct {
        logic  oe_hi;
        logic  dat;
        logic  oe_lo;
        string tag;
    } exp_t;

    exp_t        sbq[$];
    logic [15:0] model_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    bit          exp_ur = 1'b0;
    bit          done = 1'b0;

    task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    function automatic exp_t mk(input logic h, input logic d, input logic l, input string t);
        exp_t e;
        e.oe_hi = h; e.dat = d; e.oe_lo = l; e.tag = t;
        return e;
    endfunction

    // Monitor: pops one expectation per bit period and compares both halves.
    initial begin
        forever begin
            @(posedge bclk);
            repeat (PROBE) @(negedge clk);
            if (sbq.size() > 0) begin
                exp_t e;
                logic hi_oe, hi_d;
                e = sbq.pop_front();
                hi_oe = tx_oe;
                hi_d  = tx_data;
                @(negedge bclk);
                repeat (PROBE) @(negedge clk);
                chk(hi_oe == e.oe_hi, e.tag, "oe high phase", hi_oe, e.oe_hi);
                if (e.oe_hi) chk(hi_d == e.dat, e.tag, "data bit", hi_d, e.dat);
                chk(tx_oe == e.oe_lo, e.tag, "oe low phase", tx_oe, e.oe_lo);
            end
        end
    end

    task automatic half(input logic b, input logic fs);
        @(negedge clk);
        bclk = b;
        if (!b) fsync = fs;
        repeat (HALF - 1) @(negedge clk);
    endtask

    task automatic period(input logic fs, input exp_t e);
        sbq.push_back(e);
        half(1'b1, 1'b0);
        half(1'b0, fs);
    endtask

    task automatic push_word(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        if (model_q.size() < 16) model_q.push_back(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: builds the expected per-bit stream for one frame from the requirements.
    task automatic play_frame(input bit chain, input string tag);
        int          nsl = net_mode ? int'(slot_last) + 1 : 1;
        int          wb  = wide_words ? 16 : 8;
        logic        live [4];
        logic [15:0] w [4];
        for (int s = 0; s < 4; s++) begin
            live[s] = (s < nsl) && (!net_mode || slot_en[s]);
            w[s] = '0;
            if (live[s]) begin
                if (model_q.size() > 0) w[s] = model_q.pop_front();
                else exp_ur = 1'b1;
            end
        end
        for (int s = 0; s < nsl; s++) begin
            for (int b = 0; b < wb; b++) begin
                bit last   = (b == wb - 1);
                bit follow = (s < nsl - 1) ? live[s+1] : (chain && (!net_mode || slot_en[0]));
                logic lo   = live[s] && (!last || follow);
                period(chain && last && (s == nsl - 1), mk(live[s], w[s][wb-1-b], lo, tag));
            end
        end
    endtask

    task automatic settle();
        repeat (2 * HALF) @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(tx_oe == 1'b0, "R1", "tx_oe after reset", tx_oe, 0);
        chk(tx_underrun == 1'b0, "R1", "underrun after reset", tx_underrun, 0);
        chk(fifo_full == 1'b0, "R1", "fifo_full after reset", fifo_full, 0);
        tx_enable = 1'b1;
        period(1'b0, mk(0, 0, 0, "R1 no sync"));
        period(1'b0, mk(0, 0, 0, "R1 no sync"));

        // R2 R4 R8 R9: single-slot 16-bit, two frames back to back
        push_word(16'hA5C3);
        push_word(16'h1234);
        period(1'b1, mk(0, 0, 0, "R2 sync"));
        play_frame(1'b1, "R2 R4 R9 chained frame");
        play_frame(1'b0, "R8 last frame");
        period(1'b0, mk(0, 0, 0, "R8 idle"));
        settle();

        // R4 R5: 8-bit words, slot enables ignored in single-slot mode
        wide_words = 1'b0;
        slot_en = 4'h0;
        push_word(16'h5A96);
        period(1'b1, mk(0, 0, 0, "R5 sync"));
        play_frame(1'b0, "R4 R5 short word");
        period(1'b0, mk(0, 0, 0, "R5 idle"));
        settle();

        // R6 R7: four slots, slot 2 disabled, 8-bit
        net_mode = 1'b1;
        slot_last = 2'd3;
        slot_en = 4'b1011;
        push_word(16'hFFC1);
        push_word(16'h00E7);
        push_word(16'h3318);
        period(1'b1, mk(0, 0, 0, "R7 sync"));
        play_frame(1'b0, "R6 R7 gap slot");
        period(1'b0, mk(0, 0, 0, "R7 idle"));
        settle();
        chk(tx_underrun == 1'b0, "R7", "no extra pop", tx_underrun, 0);

        // R6: two slots, 16-bit
        wide_words = 1'b1;
        slot_last = 2'd1;
        slot_en = 4'b0011;
        push_word(16'hC0DE);
        push_word(16'h0F0F);
        period(1'b1, mk(0, 0, 0, "R6 sync"));
        play_frame(1'b0, "R6 two slots");
        period(1'b0, mk(0, 0, 0, "R6 idle"));
        settle();

        // R10: fill past depth, drain through four chained frames
        slot_last = 2'd3;
        slot_en = 4'hF;
        for (int i = 0; i < 16; i++) push_word(16'h8001 + 16'(i * 16'h0111));
        @(negedge clk);
        chk(fifo_full == 1'b1, "R10", "fifo_full at 16", fifo_full, 1);
        push_word(16'hBEEF);
        period(1'b1, mk(0, 0, 0, "R10 sync"));
        play_frame(1'b1, "R10 drain");
        play_frame(1'b1, "R10 drain");
        play_frame(1'b1, "R10 drain");
        play_frame(1'b0, "R10 drain");
        period(1'b0, mk(0, 0, 0, "R10 idle"));
        settle();
        chk(tx_underrun == 1'b0, "R10", "underrun after drain", tx_underrun, 0);
        chk(fifo_full == 1'b0, "R10", "fifo_full after drain", fifo_full, 0);

        // R11: empty FIFO gives zero words and sets the sticky flag
        period(1'b1, mk(0, 0, 0, "R11 sync"));
        play_frame(1'b0, "R11 zeros");
        period(1'b0, mk(0, 0, 0, "R11 idle"));
        settle();
        chk(tx_underrun == 1'b1, "R11", "underrun set", tx_underrun, 1);
        period(1'b0, mk(0, 0, 0, "R11 idle"));
        settle();
        chk(tx_underrun == 1'b1, "R11", "underrun sticky", tx_underrun, 1);

        // R12: disable mid-word
        net_mode = 1'b0;
        push_word(16'hFFFF);
        half(1'b1, 1'b0);
        half(1'b0, 1'b1);
        half(1'b1, 1'b0);
        repeat (PROBE - HALF + 1) @(negedge clk);
        chk(tx_oe == 1'b1, "R12", "driving before disable", tx_oe, 1);
        half(1'b0, 1'b0);
        @(negedge clk);
        tx_enable = 1'b0;
        repeat (3) @(negedge clk);
        chk(tx_oe == 1'b0, "R12", "oe after disable", tx_oe, 0);
        @(negedge clk);
        tx_enable = 1'b1;
        period(1'b0, mk(0, 0, 0, "R12 no resume"));
        period(1'b0, mk(0, 0, 0, "R12 no resume"));
        settle();
        finish_run();
    end
endmodule